// File: doc/BRIEF.md
# Receive-Fill Request-to-Send Throttle

This block sits beside a UART receive FIFO and paces the far-end transmitter. It compares the FIFO fill count against a programmable trigger level and drives an active-low handshake line. The line is released (driven high) when the fill climbs to an upper mark and pulled low again only after the FIFO drains to a lower mark. The two marks sit one hysteresis step above and below the trigger. The same trigger level also raises a receive-data-ready interrupt. Reception is not stopped at that level, so the FIFO keeps filling until the handshake takes effect.

A mode bit chooses which of two physical pins carries the handshake: the request-to-send pin or the data-terminal-ready pin. The other pin is parked high. When automatic pacing is off, the handshake follows a manual request bit. Every change of the handshake state can latch a line-change status flag, which the host clears by reading the modem status. The enable for that flag is a gated register that accepts writes only while the extended-feature bit is set. FIFO storage, the serial receiver and the register bus are outside this block.

Top module: `rx_auto_rts`

## Requirements
- R1: While reset is asserted, and after its release until the first state change, rts_n and dtr_n are both 1 and line_chg_flag and rx_ready_irq are both 0.
- R2: With auto_en=1, a rising clock edge that samples rx_level >= upper releases the handshake: both pins read 1 after that edge. Here upper = trig_level + hyst_sel.
- R3: With auto_en=1, the handshake is asserted (selected pin 0) only by an edge that samples rx_level <= lower, where lower = trig_level - hyst_sel. Levels strictly between lower and upper leave the pins unchanged.
- R4: When trig_level + hyst_sel exceeds DEPTH, upper is DEPTH.
- R5: When hyst_sel >= trig_level, lower is 0.
- R6: pin_sel=0 routes the handshake to rts_n and holds dtr_n at 1. pin_sel=1 routes it to dtr_n and holds rts_n at 1. Pins are decoded combinationally from pin_sel and the registered handshake state.
- R7: With auto_en=0, the selected pin equals the inverse of manual_req as sampled at the previous rising edge.
- R8: A write on ien_wr updates the line-change enable to ien_wdata only when ext_feat_en=1 in the same cycle. Otherwise the write is ignored.
- R9: When the line-change enable is 1, an edge at which the handshake state changes sets line_chg_flag at that same edge.
- R10: msr_rd=1 clears line_chg_flag at the next edge. If a handshake change with the enable set happens at that same edge, the flag stays 1.
- R11: rx_ready_irq is a registered copy of (rx_level >= trig_level and rx_level != 0), with one edge of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_level | input | CNT_W | Receive FIFO fill count |
| trig_level | input | CNT_W | Receive trigger level |
| hyst_sel | input | HYST_W | Hysteresis around the trigger |
| auto_en | input | 1 | Automatic pacing enable |
| pin_sel | input | 1 | 0: request-to-send pin, 1: terminal-ready pin |
| manual_req | input | 1 | Manual handshake request (1 = assert) |
| ext_feat_en | input | 1 | Extended-feature unlock for the enable write |
| ien_wr | input | 1 | Write strobe for the line-change enable |
| ien_wdata | input | 1 | Line-change enable write value |
| msr_rd | input | 1 | Modem-status read strobe (clears the flag) |
| rts_n | output | 1 | Active-low request-to-send |
| dtr_n | output | 1 | Active-low terminal-ready |
| rx_ready_irq | output | 1 | Receive data ready at trigger |
| line_chg_flag | output | 1 | Handshake line change status |

## Verification
The flag-setting path and the flag-clearing read can land on the same edge. This happens when the host reads modem status just as the fill level crosses a threshold. The bench provokes it by raising msr_rd in the very cycle the level jumps past the upper mark. It expects the flag to survive. One cycle later it issues a plain read and expects the flag to clear. The scoreboard predicts both outcomes from the requirement rules, independently of the design.

// File: rtl/rts_ctrl_pkg.sv
package rts_ctrl_pkg;

  typedef enum logic {
    HS_RELEASED = 1'b0,
    HS_ASSERTED = 1'b1
  } hs_state_e;

  localparam int unsigned PIN_COUNT = 2;

endpackage

// File: rtl/rts_thresh.sv
module rts_thresh #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned HYST_W = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0]  trig_level,
  input  logic [HYST_W-1:0] hyst_sel,
  output logic [CNT_W-1:0]  upper_mark,
  output logic [CNT_W-1:0]  lower_mark
);

  localparam int unsigned SUM_W = CNT_W + 1;

  logic [SUM_W-1:0] sum_ext;
  logic [SUM_W-1:0] trig_ext;
  logic [SUM_W-1:0] hyst_ext;

  always_comb begin
    trig_ext = SUM_W'(trig_level);
    hyst_ext = SUM_W'(hyst_sel);
    sum_ext  = trig_ext + hyst_ext;

    if (sum_ext > SUM_W'(DEPTH)) begin
      upper_mark = CNT_W'(DEPTH);
    end else begin
      upper_mark = sum_ext[CNT_W-1:0];
    end

    if (trig_ext > hyst_ext) begin
      lower_mark = trig_level - CNT_W'(hyst_sel);
    end else begin
      lower_mark = '0;
    end
  end

endmodule

// File: rtl/rts_hyst_fsm.sv
module rts_hyst_fsm
  import rts_ctrl_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] rx_level,
  input  logic [CNT_W-1:0] upper_mark,
  input  logic [CNT_W-1:0] lower_mark,
  input  logic             auto_en,
  input  logic             manual_req,
  output logic             hs_active,
  output logic             hs_change
);

  hs_state_e state_q;
  hs_state_e state_d;

  always_comb begin
    state_d = state_q;
    if (auto_en) begin
      if (rx_level >= upper_mark) begin
        state_d = HS_RELEASED;
      end else if (rx_level <= lower_mark) begin
        state_d = HS_ASSERTED;
      end
    end else begin
      state_d = manual_req ? HS_ASSERTED : HS_RELEASED;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HS_RELEASED;
    end else if (state_d != state_q) begin
      state_q <= state_d;
    end
  end

  assign hs_active = (state_q == HS_ASSERTED);
  assign hs_change = (state_d != state_q);

endmodule

// File: rtl/rts_status.sv
module rts_status #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] rx_level,
  input  logic [CNT_W-1:0] trig_level,
  input  logic             hs_change,
  input  logic             ext_feat_en,
  input  logic             ien_wr,
  input  logic             ien_wdata,
  input  logic             msr_rd,
  output logic             chg_ien,
  output logic             line_chg_flag,
  output logic             rx_ready_irq
);

  logic ien_q;
  logic ien_load;
  logic flag_q;
  logic flag_d;
  logic rdy_q;
  logic rdy_d;

  always_comb begin
    ien_load = ien_wr & ext_feat_en;
    flag_d   = (hs_change & ien_q) | (flag_q & ~msr_rd);
    rdy_d    = (rx_level >= trig_level) && (rx_level != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= 1'b0;
    end else if (ien_load) begin
      ien_q <= ien_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      rdy_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      rdy_q  <= rdy_d;
    end
  end

  assign chg_ien       = ien_q;
  assign line_chg_flag = flag_q;
  assign rx_ready_irq  = rdy_q;

endmodule

// File: rtl/rx_auto_rts.sv
module rx_auto_rts
  import rts_ctrl_pkg::*;
#(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned HYST_W = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  rx_level,
  input  logic [CNT_W-1:0]  trig_level,
  input  logic [HYST_W-1:0] hyst_sel,
  input  logic              auto_en,
  input  logic              pin_sel,
  input  logic              manual_req,
  input  logic              ext_feat_en,
  input  logic              ien_wr,
  input  logic              ien_wdata,
  input  logic              msr_rd,
  output logic              rts_n,
  output logic              dtr_n,
  output logic              rx_ready_irq,
  output logic              line_chg_flag
);

  logic [CNT_W-1:0]     upper_mark;
  logic [CNT_W-1:0]     lower_mark;
  logic                 hs_active;
  logic                 hs_change;
  logic                 chg_ien;
  logic [PIN_COUNT-1:0] pins_n;

  rts_thresh #(.DEPTH(DEPTH), .HYST_W(HYST_W)) i_thresh (
    .trig_level (trig_level),
    .hyst_sel   (hyst_sel),
    .upper_mark (upper_mark),
    .lower_mark (lower_mark)
  );

  rts_hyst_fsm #(.DEPTH(DEPTH)) i_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_level   (rx_level),
    .upper_mark (upper_mark),
    .lower_mark (lower_mark),
    .auto_en    (auto_en),
    .manual_req (manual_req),
    .hs_active  (hs_active),
    .hs_change  (hs_change)
  );

  rts_status #(.DEPTH(DEPTH)) i_status (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_level      (rx_level),
    .trig_level    (trig_level),
    .hs_change     (hs_change),
    .ext_feat_en   (ext_feat_en),
    .ien_wr        (ien_wr),
    .ien_wdata     (ien_wdata),
    .msr_rd        (msr_rd),
    .chg_ien       (chg_ien),
    .line_chg_flag (line_chg_flag),
    .rx_ready_irq  (rx_ready_irq)
  );

  // Pin 0 is request-to-send, pin 1 is terminal-ready; unselected pin parks high.
  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
    assign pins_n[p] = ((pin_sel == 1'(p)) && hs_active) ? 1'b0 : 1'b1;
  end

  assign rts_n = pins_n[0];
  assign dtr_n = pins_n[1];

endmodule

// File: rtl/rx_auto_rts_chk.sv
module rx_auto_rts_chk #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned HYST_W = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CNT_W-1:0]  rx_level,
  input logic [CNT_W-1:0]  trig_level,
  input logic [HYST_W-1:0] hyst_sel,
  input logic              auto_en,
  input logic              pin_sel,
  input logic              manual_req,
  input logic              msr_rd,
  input logic              rts_n,
  input logic              dtr_n,
  input logic              rx_ready_irq,
  input logic              line_chg_flag
);

  int unsigned up_i;
  int unsigned lo_i;
  logic        released;

  always_comb begin
    up_i = int'(trig_level) + int'(hyst_sel);
    if (up_i > DEPTH) up_i = DEPTH;
    lo_i = (int'(trig_level) > int'(hyst_sel)) ? int'(trig_level) - int'(hyst_sel) : 0;
    released = rts_n & dtr_n;
  end

  a_r6_one_pin_low: assert property (@(posedge clk) disable iff (!rst_n)
    pin_sel ? rts_n : dtr_n);

  a_r2_release_at_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && int'(rx_level) >= up_i) |=> released);

  a_r3_hold_in_band: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && int'(rx_level) > lo_i && int'(rx_level) < up_i) |=> $stable(released));

  a_r7_manual_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_en) |=> (released == !$past(manual_req)));

  a_r9_flag_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_chg_flag) |-> (released != $past(released)));

  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_rd && line_chg_flag) |=> (!line_chg_flag || (released != $past(released))));

  a_r11_ready_level: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rx_ready_irq == ($past(rx_level) >= $past(trig_level) && $past(rx_level) != '0)));

endmodule

bind rx_auto_rts rx_auto_rts_chk #(.DEPTH(DEPTH), .HYST_W(HYST_W)) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rx_level      (rx_level),
  .trig_level    (trig_level),
  .hyst_sel      (hyst_sel),
  .auto_en       (auto_en),
  .pin_sel       (pin_sel),
  .manual_req    (manual_req),
  .msr_rd        (msr_rd),
  .rts_n         (rts_n),
  .dtr_n         (dtr_n),
  .rx_ready_irq  (rx_ready_irq),
  .line_chg_flag (line_chg_flag)
);

// File: tb/test_rx_auto_rts.sv
module test_rx_auto_rts;

  localparam int unsigned DEPTH  = 64;
  localparam int unsigned HYST_W = 4;
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1);
  localparam time CLK_PERIOD = 10ns;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [CNT_W-1:0]  rx_level;
  logic [CNT_W-1:0]  trig_level;
  logic [HYST_W-1:0] hyst_sel;
  logic auto_en, pin_sel, manual_req, ext_feat_en, ien_wr, ien_wdata, msr_rd;
  logic rts_n, dtr_n, rx_ready_irq, line_chg_flag;

  int n_cmp = 0;
  int n_bad = 0;

  logic [3:0] exp_q[$];
  string      tag_q[$];

  int m_req  = 0;
  int m_flag = 0;
  int m_ien  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rx_auto_rts #(.DEPTH(DEPTH), .HYST_W(HYST_W)) i_rx_auto_rts (
    .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .trig_level(trig_level),
    .hyst_sel(hyst_sel), .auto_en(auto_en), .pin_sel(pin_sel),
    .manual_req(manual_req), .ext_feat_en(ext_feat_en), .ien_wr(ien_wr),
    .ien_wdata(ien_wdata), .msr_rd(msr_rd), .rts_n(rts_n), .dtr_n(dtr_n),
    .rx_ready_irq(rx_ready_irq), .line_chg_flag(line_chg_flag)
  );

  task automatic compare(string tag, logic [3:0] got, logic [3:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: {rts_n,dtr_n,flag,rdy} actual %b expected %b", tag, got, exp);
    end
  endtask

  // Monitor: pops one expectation per edge, shortly after the edge.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      compare(tag_q.pop_front(), {rts_n, dtr_n, line_chg_flag, rx_ready_irq}, exp_q.pop_front());
    end
  end

  // Driver: applies one cycle of stimulus and predicts the result of the next edge.
  task automatic step(string tag, int lvl, int trg, int hys, bit aut, bit sel,
                      bit man, bit efe, bit iwr, bit idat, bit rd);
    int up, lo, nreq, chg, rdy;
    @(negedge clk);
    rx_level = CNT_W'(lvl); trig_level = CNT_W'(trg); hyst_sel = HYST_W'(hys);
    auto_en = aut; pin_sel = sel; manual_req = man; ext_feat_en = efe;
    ien_wr = iwr; ien_wdata = idat; msr_rd = rd;
    up = (trg + hys > DEPTH) ? DEPTH : trg + hys;
    lo = (trg > hys) ? trg - hys : 0;
    if (aut) nreq = (lvl >= up) ? 0 : ((lvl <= lo) ? 1 : m_req);
    else     nreq = man ? 1 : 0;
    chg    = (nreq != m_req) ? 1 : 0;
    m_flag = ((chg != 0) && (m_ien != 0)) || ((m_flag != 0) && !rd) ? 1 : 0;
    if (iwr && efe) m_ien = idat ? 1 : 0;
    m_req = nreq;
    rdy = (lvl >= trg && lvl != 0) ? 1 : 0;
    exp_q.push_back({(sel || m_req == 0), (!sel || m_req == 0), m_flag[0], rdy[0]});
    tag_q.push_back(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    rx_level = '0; trig_level = CNT_W'(32); hyst_sel = HYST_W'(8);
    auto_en = 1'b0; pin_sel = 1'b0; manual_req = 1'b0; ext_feat_en = 1'b0;
    ien_wr = 1'b0; ien_wdata = 1'b0; msr_rd = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    compare("R1 reset", {rts_n, dtr_n, line_chg_flag, rx_ready_irq}, 4'b1100);
    @(negedge clk);
    rst_n = 1'b1;

    // trig 32, hyst 8: upper 40, lower 24
    step("R8 locked write",  0, 32, 8, 1, 0, 0, 0, 1, 1, 0);
    step("R2 R8 no flag",   40, 32, 8, 1, 0, 0, 0, 0, 0, 0);
    step("R8 unlocked",      0, 32, 8, 1, 0, 0, 1, 1, 1, 0);
    step("R3 band hold",    30, 32, 8, 1, 0, 0, 0, 0, 0, 0);
    step("R2 below upper",  39, 32, 8, 1, 0, 0, 0, 0, 0, 0);
    step("R2 R9 at upper",  40, 32, 8, 1, 0, 0, 0, 0, 0, 0);
    step("R10 read clear",  35, 32, 8, 1, 0, 0, 0, 0, 0, 1);
    step("R3 above lower",  25, 32, 8, 1, 0, 0, 0, 0, 0, 0);
    step("R3 R9 at lower",  24, 32, 8, 1, 0, 0, 0, 0, 0, 0);
    step("R10 set wins",    45, 32, 8, 1, 0, 0, 0, 0, 0, 1);
    step("R10 plain read",  45, 32, 8, 1, 0, 0, 0, 0, 0, 1);
    step("R6 dtr select",   10, 32, 8, 1, 1, 0, 0, 0, 0, 1);
    step("R6 dtr hold",     10, 32, 8, 1, 1, 0, 0, 0, 0, 1);
    step("R4 clamp hold",   63, 60, 8, 1, 0, 0, 0, 0, 0, 1);
    step("R4 clamp depth",  64, 60, 8, 1, 0, 0, 0, 0, 0, 1);
    step("R5 floor hold",    4,  4, 8, 1, 0, 0, 0, 0, 0, 1);
    step("R5 floor zero",    0,  4, 8, 1, 0, 0, 0, 0, 0, 1);
    step("R7 manual off",   20, 32, 8, 0, 0, 0, 0, 0, 0, 1);
    step("R7 manual on",    50, 32, 8, 0, 1, 1, 0, 0, 0, 1);
    step("R8 disable",      50, 32, 8, 0, 1, 1, 1, 1, 0, 1);
    step("R8 disabled chg", 50, 32, 8, 0, 1, 0, 0, 0, 0, 0);
    step("R11 zero level",   0,  0, 8, 1, 0, 0, 0, 0, 0, 0);
    step("R11 at trigger",  16, 16, 2, 1, 0, 0, 0, 0, 0, 0);
    step("R11 below",       15, 16, 2, 1, 0, 0, 0, 0, 0, 0);
    step("R3 hyst zero",    16, 16, 0, 1, 0, 0, 0, 0, 0, 0);
    step("R3 hyst zero lo", 15, 16, 0, 1, 0, 0, 0, 0, 0, 0);

    @(negedge clk);
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule